// File: doc/BRIEF.md
# AHB to APB Peripheral Bridge

This block sits as a slave on a pipelined AHB-style system bus and acts as the only master of a slow, non-pipelined APB-style peripheral bus. Every accepted AHB beat becomes one two-phase peripheral transfer. A beat can be a single transfer or one beat of an incrementing burst. The bridge keeps the AHB data phase stalled with its ready output low until the peripheral transfer has finished.

The peripheral side is not driven by a second clock. It advances on a one-cycle clock enable that fires once every `RATIO` system clocks. The bridge brings this enable out so that peripherals can sample on the same edges. The address space is split into pages. The page number, taken from the upper address bits, picks one peripheral select line. The lower bits pass through unchanged to address a register inside that peripheral. An address whose page has no peripheral gets a two-cycle error response and causes no peripheral activity.

Top module: `ahb_apb_bridge`

## Requirements
- R1: After reset, `ahb_ready` is 1, `ahb_err` is 0, and `per_sel` and `per_enable` are all 0.
- R2: Each peripheral transfer first holds a setup phase of exactly `RATIO` clocks, with its select line high and `per_enable` low. It then holds an access phase of exactly `RATIO` clocks with `per_enable` high. `per_enable` is never high without a select line.
- R3: `per_tick` is high for one clock in every `RATIO` clocks, with `RATIO` an integer parameter (default 12, supported 12 to 16). `per_sel` and `per_enable` change only on an edge where `per_tick` was high.
- R4: On a write, `per_addr` carries the accepted AHB address and `per_write` is 1. `per_wdata` carries the `ahb_wdata` value driven in the first data-phase cycle. All three stay stable while `per_enable` is high.
- R5: On a read, `ahb_rdata` returns the `per_rdata` value present at the end of the access phase. It is valid in the cycle where `ahb_ready` returns high, with `ahb_err` 0 (OKAY).
- R6: `ahb_ready` is low from the first data-phase cycle until the peripheral access phase ends, and it is low whenever any select line is high.
- R7: `ahb_trans` uses the codes 00 idle, 01 busy, 10 non-sequential and 11 sequential. Each beat of an incrementing burst (10 followed by 11 beats) becomes its own separate peripheral transfer, and the select line drops between beats.
- R8: The page number is `ahb_addr[ADDR_W-1:PAGE_LSB]`. Page k with k < `N_PERIPH` drives only `per_sel[k]`. At most one select line is high at a time.
- R9: An access to a page ≥ `N_PERIPH` asserts no select line. It gets an error response: one cycle with `ahb_ready` 0 and `ahb_err` 1, then one cycle with `ahb_ready` 1 and `ahb_err` 1.
- R10: A beat with `ahb_sel` low, or with `ahb_trans` idle (00) or busy (01), starts no peripheral transfer and leaves `ahb_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ahb_sel | input | 1 | Bridge selected for the current address phase |
| ahb_addr | input | ADDR_W | Address-phase address |
| ahb_trans | input | 2 | Transfer kind: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| ahb_write | input | 1 | 1 = write, 0 = read |
| ahb_wdata | input | DATA_W | Write data, valid in the data phase |
| ahb_ready | output | 1 | Data phase completes / next address accepted |
| ahb_err | output | 1 | 0 = OKAY, 1 = ERROR response |
| ahb_rdata | output | DATA_W | Read data returned to the system bus |
| per_tick | output | 1 | Peripheral-side clock enable, one clock in RATIO |
| per_addr | output | ADDR_W | Shared peripheral address |
| per_write | output | 1 | Shared peripheral direction |
| per_wdata | output | DATA_W | Shared peripheral write data |
| per_sel | output | N_PERIPH | One select line per peripheral |
| per_enable | output | 1 | Access-phase strobe |
| per_rdata | input | DATA_W | Read data from the selected peripheral |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. They check that the enable strobe appears only under a select and only after a setup cycle. They check that select and enable move only on tick edges and that at most one select is high. They also check that the shared address and data hold during access, that the AHB side stays stalled while a select is up, and that the error response has its two-cycle shape. Other results depend on data and counts, and only the bench scenarios can show them. These are: written data arriving at the right peripheral and register, read data coming back on the system bus, a burst splitting into the right number of separate transfers, phase lengths equal to `RATIO`, and idle, busy or deselected beats leaving the peripheral bus quiet.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  typedef enum logic [2:0] {
    ST_READY,   // data phase complete, address phase open
    ST_CAPT,    // first data-phase cycle: latch write data
    ST_WAIT,    // wait for the next peripheral tick
    ST_SETUP,   // peripheral setup phase
    ST_ACCESS,  // peripheral access phase
    ST_ERR1,    // error response, stall cycle
    ST_ERR2     // error response, completion cycle
  } bstate_e;

endpackage

// File: rtl/per_tick_gen.sv
module per_tick_gen #(
  parameter int RATIO = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R3: the enable is a single-cycle pulse
  p_tick_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/page_decode.sv
module page_decode #(
  parameter int PAGE_W   = 20,
  parameter int N_PERIPH = 4
) (
  input  logic [PAGE_W-1:0]   page,
  output logic [N_PERIPH-1:0] sel,
  output logic                hit
);
  for (genvar k = 0; k < N_PERIPH; k++) begin : g_page
    assign sel[k] = (page == PAGE_W'(k));
  end

  assign hit = |sel;

endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 4,
  parameter int PAGE_LSB = 12,
  parameter int RATIO    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ahb_sel,
  input  logic [ADDR_W-1:0]   ahb_addr,
  input  logic [1:0]          ahb_trans,
  input  logic                ahb_write,
  input  logic [DATA_W-1:0]   ahb_wdata,
  output logic                ahb_ready,
  output logic                ahb_err,
  output logic [DATA_W-1:0]   ahb_rdata,
  output logic                per_tick,
  output logic [ADDR_W-1:0]   per_addr,
  output logic                per_write,
  output logic [DATA_W-1:0]   per_wdata,
  output logic [N_PERIPH-1:0] per_sel,
  output logic                per_enable,
  input  logic [DATA_W-1:0]   per_rdata
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  bstate_e               state;
  logic [N_PERIPH-1:0]   sel_q;
  logic [N_PERIPH-1:0]   dec_sel;
  logic                  dec_hit;
  logic                  accept;

  per_tick_gen #(.RATIO(RATIO)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (per_tick)
  );

  page_decode #(.PAGE_W(PAGE_W), .N_PERIPH(N_PERIPH)) u_dec (
    .page (ahb_addr[ADDR_W-1:PAGE_LSB]),
    .sel  (dec_sel),
    .hit  (dec_hit)
  );

  assign ahb_ready  = (state == ST_READY) || (state == ST_ERR2);
  assign ahb_err    = (state == ST_ERR1)  || (state == ST_ERR2);
  assign per_enable = (state == ST_ACCESS);
  assign per_sel    = ((state == ST_SETUP) || (state == ST_ACCESS)) ? sel_q : '0;
  assign accept     = ahb_sel && ahb_ready &&
                      ((ahb_trans == TR_NONSEQ) || (ahb_trans == TR_SEQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_READY;
      sel_q     <= '0;
      per_addr  <= '0;
      per_write <= 1'b0;
      per_wdata <= '0;
      ahb_rdata <= '0;
    end else begin
      unique case (state)
        ST_READY, ST_ERR2: begin
          if (accept) begin
            per_addr  <= ahb_addr;
            per_write <= ahb_write;
            sel_q     <= dec_sel;
            state     <= dec_hit ? ST_CAPT : ST_ERR1;
          end else begin
            state <= ST_READY;
          end
        end
        ST_CAPT: begin
          if (per_write) per_wdata <= ahb_wdata;
          state <= ST_WAIT;
        end
        ST_WAIT:   if (per_tick) state <= ST_SETUP;
        ST_SETUP:  if (per_tick) state <= ST_ACCESS;
        ST_ACCESS: begin
          if (per_tick) begin
            if (!per_write) ahb_rdata <= per_rdata;
            state <= ST_READY;
          end
        end
        ST_ERR1:   state <= ST_ERR2;
        default:   state <= ST_READY;
      endcase
    end
  end

  // R2: access strobe only under a select, and only after a setup cycle
  p_enable_has_sel_r2: assert property (@(posedge clk) disable iff (rst)
    per_enable |-> (|per_sel));
  p_setup_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(per_enable) |-> $past(|per_sel));
  // R3: peripheral phases move only on tick edges
  p_phase_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(per_tick) |-> ($stable(per_sel) && $stable(per_enable)));
  // R4: shared bus held during access
  p_bus_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (per_enable && $past(per_enable)) |->
      ($stable(per_addr) && $stable(per_wdata) && $stable(per_write)));
  // R6: system side stalled while a peripheral is selected
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (|per_sel) |-> !ahb_ready);
  // R8: at most one select line
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_sel));
  // R9: error response selects nothing and has its two-cycle shape
  p_err_nosel_r9: assert property (@(posedge clk) disable iff (rst)
    ahb_err |-> (per_sel == '0));
  p_err_shape_r9: assert property (@(posedge clk) disable iff (rst)
    (ahb_err && !ahb_ready) |=> (ahb_err && ahb_ready));

endmodule

// File: tb/sim_ahb_apb_bridge.sv
module sim_ahb_apb_bridge;
  localparam int RATIO = 12;
  localparam int NP    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ahb_sel = 1'b0;
  logic [31:0] ahb_addr = '0;
  logic [1:0]  ahb_trans = 2'b00;
  logic        ahb_write = 1'b0;
  logic [31:0] ahb_wdata = '0;
  logic        ahb_ready, ahb_err;
  logic [31:0] ahb_rdata;
  logic        per_tick, per_write, per_enable;
  logic [31:0] per_addr, per_wdata;
  logic [NP-1:0] per_sel;
  logic [31:0] per_rdata;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ahb_apb_bridge #(.ADDR_W(32), .DATA_W(32), .N_PERIPH(NP), .PAGE_LSB(12), .RATIO(RATIO)) u0 (
    .clk(clk), .rst(rst), .ahb_sel(ahb_sel), .ahb_addr(ahb_addr), .ahb_trans(ahb_trans),
    .ahb_write(ahb_write), .ahb_wdata(ahb_wdata), .ahb_ready(ahb_ready), .ahb_err(ahb_err),
    .ahb_rdata(ahb_rdata), .per_tick(per_tick), .per_addr(per_addr), .per_write(per_write),
    .per_wdata(per_wdata), .per_sel(per_sel), .per_enable(per_enable), .per_rdata(per_rdata));

  // peripheral register model and bus monitor
  logic [31:0] mem [NP][16];
  int xfer_cnt = 0, sel_cyc = 0, en_cyc = 0;
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic last_write = 1'b0;
  logic [NP-1:0] last_sel = '0;
  logic prev_any = 1'b0;

  initial for (int k = 0; k < NP; k++) for (int j = 0; j < 16; j++) mem[k][j] = 32'hDEAD_0000 + k * 16 + j;

  always_comb begin
    per_rdata = '0;
    for (int k = 0; k < NP; k++) if (per_sel[k]) per_rdata = mem[k][per_addr[5:2]];
  end

  always @(posedge clk) begin
    if (!rst) begin
      prev_any <= |per_sel;
      if ((|per_sel) && !prev_any) xfer_cnt <= xfer_cnt + 1;
      if (|per_sel) sel_cyc <= sel_cyc + 1;
      if (per_enable) en_cyc <= en_cyc + 1;
      if (per_tick && per_enable) begin
        last_addr <= per_addr; last_wdata <= per_wdata;
        last_write <= per_write; last_sel <= per_sel;
        for (int k = 0; k < NP; k++)
          if (per_sel[k] && per_write) mem[k][per_addr[5:2]] <= per_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ahb_single(input logic [31:0] a, input bit w, input logic [31:0] wd,
                            output logic [31:0] rd, output bit err, output bit err_low, output int stall);
    @(negedge clk);
    ahb_sel = 1; ahb_addr = a; ahb_trans = 2'b10; ahb_write = w;
    while (!ahb_ready) @(negedge clk);
    @(negedge clk);
    ahb_wdata = wd; ahb_trans = 2'b00; ahb_sel = 0;
    stall = 0; err_low = 0;
    while (!ahb_ready) begin
      stall++;
      if (ahb_err) err_low = 1;
      @(negedge clk);
    end
    rd = ahb_rdata; err = ahb_err;
  endtask

  task automatic ahb_burst4(input logic [31:0] base, input bit w, input logic [31:0] wd [4],
                            output logic [31:0] rd [4]);
    @(negedge clk);
    ahb_sel = 1; ahb_addr = base; ahb_trans = 2'b10; ahb_write = w;
    while (!ahb_ready) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ahb_wdata = wd[i];
      if (i < 3) begin ahb_addr = base + 32'(4 * (i + 1)); ahb_trans = 2'b11; end
      else begin ahb_trans = 2'b00; ahb_sel = 0; end
      while (!ahb_ready) @(negedge clk);
      rd[i] = ahb_rdata;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ahb_ready == 1'b1, "R1 ready", 32'(ahb_ready), 32'd1);
    chk(ahb_err == 1'b0, "R1 err", 32'(ahb_err), 32'd0);
    chk(per_sel == '0 && per_enable == 1'b0, "R1 sel/enable", {per_sel, 3'b0, per_enable}, 32'd0);
  endtask

  task automatic t_tick();
    int n = 0, last = -1, gap_bad = 0;
    for (int c = 0; c < 4 * RATIO; c++) begin
      @(negedge clk);
      if (per_tick) begin
        if (last >= 0 && c - last != RATIO) gap_bad++;
        last = c; n++;
      end
    end
    chk(n == 4, "R3 tick count", 32'(n), 32'd4);
    chk(gap_bad == 0, "R3 tick spacing", 32'(gap_bad), 32'd0);
  endtask

  task automatic t_single();
    logic [31:0] rd; bit err, el; int st, x0, s0, e0;
    x0 = xfer_cnt; s0 = sel_cyc; e0 = en_cyc;
    ahb_single(32'h0000_100C, 1, 32'hA5A5_1234, rd, err, el, st);
    chk(xfer_cnt - x0 == 1, "R4 one transfer", 32'(xfer_cnt - x0), 32'd1);
    chk(last_addr == 32'h0000_100C, "R4 addr", last_addr, 32'h0000_100C);
    chk(last_wdata == 32'hA5A5_1234, "R4 wdata", last_wdata, 32'hA5A5_1234);
    chk(last_write == 1'b1, "R4 write", 32'(last_write), 32'd1);
    chk(last_sel == 4'b0010, "R8 page1 sel", 32'(last_sel), 32'b0010);
    chk(sel_cyc - s0 == 2 * RATIO, "R2 select cycles", 32'(sel_cyc - s0), 32'(2 * RATIO));
    chk(en_cyc - e0 == RATIO, "R2 enable cycles", 32'(en_cyc - e0), 32'(RATIO));
    chk(st >= 2 * RATIO, "R6 stall length", 32'(st), 32'(2 * RATIO));
    chk(err == 1'b0, "R5 write OKAY", 32'(err), 32'd0);
    ahb_single(32'h0000_100C, 0, 32'h0, rd, err, el, st);
    chk(rd == 32'hA5A5_1234, "R5 read data", rd, 32'hA5A5_1234);
    chk(err == 1'b0, "R5 read OKAY", 32'(err), 32'd0);
    chk(last_write == 1'b0, "R5 read direction", 32'(last_write), 32'd0);
  endtask

  task automatic t_burst();
    logic [31:0] wd [4], rd [4], z [4];
    int x0, e0;
    for (int i = 0; i < 4; i++) begin wd[i] = 32'h1111_0000 + i; z[i] = '0; end
    x0 = xfer_cnt; e0 = en_cyc;
    ahb_burst4(32'h0000_2010, 1, wd, rd);
    chk(xfer_cnt - x0 == 4, "R7 burst write transfers", 32'(xfer_cnt - x0), 32'd4);
    chk(en_cyc - e0 == 4 * RATIO, "R7 burst enable cycles", 32'(en_cyc - e0), 32'(4 * RATIO));
    x0 = xfer_cnt;
    ahb_burst4(32'h0000_2010, 0, z, rd);
    chk(xfer_cnt - x0 == 4, "R7 burst read transfers", 32'(xfer_cnt - x0), 32'd4);
    for (int i = 0; i < 4; i++)
      chk(rd[i] == wd[i], "R7 burst beat data", rd[i], wd[i]);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; bit err, el; int st, x0;
    x0 = xfer_cnt;
    ahb_single(32'h0000_7004, 1, 32'h5555_AAAA, rd, err, el, st);
    chk(err == 1'b1 && el == 1'b1, "R9 error both cycles", {30'b0, err, el}, 32'b11);
    chk(st == 1, "R9 one stall cycle", 32'(st), 32'd1);
    ahb_single(32'h8000_0000, 0, 32'h0, rd, err, el, st);
    chk(err == 1'b1 && st == 1, "R9 high page read", 32'(st), 32'd1);
    chk(xfer_cnt - x0 == 0, "R9 no select", 32'(xfer_cnt - x0), 32'd0);
  endtask

  task automatic t_ignored();
    int x0, low = 0;
    x0 = xfer_cnt;
    @(negedge clk);
    ahb_sel = 1; ahb_addr = 32'h0000_0008; ahb_write = 1; ahb_trans = 2'b00;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (!ahb_ready) low++; end
    ahb_trans = 2'b01;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (!ahb_ready) low++; end
    ahb_sel = 0; ahb_trans = 2'b10;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (!ahb_ready) low++; end
    ahb_trans = 2'b00;
    chk(low == 0, "R10 ready stays high", 32'(low), 32'd0);
    chk(xfer_cnt - x0 == 0, "R10 no transfer", 32'(xfer_cnt - x0), 32'd0);
  endtask

  task automatic t_all_pages();
    logic [31:0] rd; bit err, el; int st;
    for (int p = 0; p < NP; p++) begin
      ahb_single(32'(p << 12) + 32'h4, 1, 32'hC0DE_0000 + 32'(p), rd, err, el, st);
      chk(last_sel == NP'(1 << p), "R8 select line", 32'(last_sel), 32'(1 << p));
    end
    for (int p = 0; p < NP; p++) begin
      ahb_single(32'(p << 12) + 32'h4, 0, 32'h0, rd, err, el, st);
      chk(rd == 32'hC0DE_0000 + 32'(p), "R8 page data", rd, 32'hC0DE_0000 + 32'(p));
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_tick();
    t_single();
    t_burst();
    t_unmapped();
    t_ignored();
    t_all_pages();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule